// File: doc/BRIEF.md
# DMA Channel Event Flag Register

This block holds the event flags of a DMA controller with up to seven channels. Each channel engine delivers single-cycle pulses for three kinds of event: a transfer error, reaching the half-way point of a transfer, and completing a transfer. The block latches each pulse into a sticky flag. It also keeps a per-channel summary flag that records that at least one of the three events has happened.

Software reads all flags through one 32-bit status word. It acknowledges flags by writing ones to a separate clear word. The bus accepts byte, half-word and word accesses, and the byte enables limit which flags a clear write can reach.

Each channel has an interrupt request output. The request is gated by that channel's enable input. A parameter reduces the controller to five channels. In that case the two upper channels are inert.

Top module: `dma_evt_flags`

## Requirements
- R1: After reset every flag is zero, every interrupt output is low, and a read of the status word returns 0x00000000.
- R2: The status word sits at byte offset 0x00. Channel x (1 to 7) uses bits 4*(x-1)+3 down to 4*(x-1). Within that nibble, bit 0 is the summary flag, bit 1 is transfer complete, bit 2 is half transfer and bit 3 is transfer error.
- R3: An event pulse on a channel's error, half or complete input is sampled at a rising clock edge. From that edge the matching flag reads 1, and so does the channel's summary flag.
- R4: A write to byte offset 0x04 clears every flag whose bit position holds a 1 in the written data. Bits written as 0 leave their flags unchanged.
- R5: Writing 1 to a channel's summary-flag clear bit clears all four flags of that channel.
- R6: A clear write acts only on the byte lanes whose byte enable bit is 1. Lane n covers data bits 8n+7 to 8n.
- R7: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: Bits 31:28 of the status word always read 0. A read of offset 0x04 returns 0. A write to offset 0x00 changes no flag.
- R9: With the channel count parameter set to 5, the flags of channels 6 and 7 read 0, those channels ignore events, and their interrupt outputs stay low.
- R10: A channel's interrupt output is high exactly when that channel's enable input is high and at least one of its flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ev_err | input | 7 | Per-channel transfer error pulses |
| ev_half | input | 7 | Per-channel half-transfer pulses |
| ev_done | input | 7 | Per-channel transfer-complete pulses |
| irq_en | input | 7 | Per-channel interrupt enables |
| irq | output | 7 | Per-channel interrupt requests |

## Verification
Some properties are checked by assertions on every cycle:
- a set beats a same-cycle clear;
- a flag cleared without a competing event reads zero on the next cycle;
- the summary flag is always high whenever any event flag of its channel is high;
- a summary clear empties the whole nibble;
- an interrupt is never raised while its enable is low;
- a read of the clear word always returns zero.

Other behaviour only the bench scenarios can show. This covers the nibble layout seen from the bus, byte-lane masking of clear data, and the fact that writes to the status offset change nothing. It also covers the inert upper channels of a five-channel instance. The bench compares both a seven-channel and a five-channel instance against a reference model under random event, enable and clear traffic.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
   localparam int MAX_CH   = 7;
   localparam int NIB_W    = 4;
   localparam int DATA_W   = 32;
   localparam int BE_W     = DATA_W / 8;
   // nibble bit positions (decoded by software, so fixed)
   localparam int B_SUM    = 0;
   localparam int B_DONE   = 1;
   localparam int B_HALF   = 2;
   localparam int B_ERR    = 3;
   localparam int OFS_STAT = 0;
   localparam int OFS_CLR  = 4;
endpackage

// File: rtl/dma_flag_clrdec.sv
module dma_flag_clrdec
   import dma_flag_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] clr_mask
);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

   logic hit;
   assign hit = sel && wr && (addr == A_CLR);

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign clr_mask[8*b +: 8] = (hit && be[b]) ? wdata[8*b +: 8] : 8'h00;
   end
endmodule

// File: rtl/dma_flag_chan.sv
module dma_flag_chan
   import dma_flag_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_err,
   input  logic             set_half,
   input  logic             set_done,
   input  logic [NIB_W-1:0] clr,
   input  logic             en,
   output logic [NIB_W-1:0] flags,
   output logic             irq
);
   logic any_set;
   logic clr_sum;
   logic [NIB_W-1:0] nxt;

   assign any_set = set_err | set_half | set_done;
   assign clr_sum = clr[B_SUM];

   always_comb begin
      nxt         = flags;
      nxt[B_ERR]  = set_err  | (flags[B_ERR]  & ~(clr[B_ERR]  | clr_sum));
      nxt[B_HALF] = set_half | (flags[B_HALF] & ~(clr[B_HALF] | clr_sum));
      nxt[B_DONE] = set_done | (flags[B_DONE] & ~(clr[B_DONE] | clr_sum));
      nxt[B_SUM]  = any_set  | (flags[B_SUM]  & ~clr_sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= nxt;
   end

   assign irq = en & (|flags);

   // R7: a set always wins against a same-cycle clear
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_err && clr[B_ERR]) |=> flags[B_ERR]);
   // R3: summary flag covers every event flag
   p_sum_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[B_ERR] || flags[B_HALF] || flags[B_DONE]) |-> flags[B_SUM]);
   // R4: clear without competing set empties the bit
   p_clr_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[B_DONE] && !set_done) |=> !flags[B_DONE]);
   // R5: summary clear without events empties the nibble
   p_sum_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sum && !any_set) |=> (flags == '0));
endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags
   import dma_flag_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [MAX_CH-1:0] ev_err,
   input  logic [MAX_CH-1:0] ev_half,
   input  logic [MAX_CH-1:0] ev_done,
   input  logic [MAX_CH-1:0] irq_en,
   output logic [MAX_CH-1:0] irq
);
   localparam int USED_W = MAX_CH * NIB_W;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

   initial begin
      a_param_ch: assert (NUM_CH == 5 || NUM_CH == 7);
      a_param_aw: assert (ADDR_W >= 3);
   end

   logic [DATA_W-1:0] clr_mask;
   logic [DATA_W-1:0] status;

   dma_flag_clrdec #(.ADDR_W(ADDR_W)) clrdec_i (
      .sel      (bus_sel),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .be       (bus_be),
      .wdata    (bus_wdata),
      .clr_mask (clr_mask)
   );

   for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
      if (c < NUM_CH) begin : g_on
         dma_flag_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_err  (ev_err[c]),
            .set_half (ev_half[c]),
            .set_done (ev_done[c]),
            .clr      (clr_mask[NIB_W*c +: NIB_W]),
            .en       (irq_en[c]),
            .flags    (status[NIB_W*c +: NIB_W]),
            .irq      (irq[c])
         );
      end else begin : g_off
         assign status[NIB_W*c +: NIB_W] = '0;
         assign irq[c] = 1'b0;
      end
   end
   assign status[DATA_W-1:USED_W] = '0;

   assign bus_rdata = (bus_sel && !bus_wr && bus_addr == A_STAT) ? status : '0;

   // R8: the clear word never reads back data
   p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == A_CLR) |-> (bus_rdata == '0));
   // R10: no request without its enable
   p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~irq_en) == '0));
endmodule

// File: tb/dma_evt_flags_tb_top.sv
module dma_evt_flags_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        bus_sel = 0, bus_wr = 0;
   logic [3:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [6:0]  ev_err = '0, ev_half = '0, ev_done = '0, irq_en = '0;
   logic [31:0] rd7, rd5;
   logic [6:0]  irq7, irq5;

   dma_evt_flags #(.NUM_CH(7), .ADDR_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(rd7), .ev_err(ev_err), .ev_half(ev_half),
      .ev_done(ev_done), .irq_en(irq_en), .irq(irq7));

   dma_evt_flags #(.NUM_CH(5), .ADDR_W(4)) dut5_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(rd5), .ev_err(ev_err), .ev_half(ev_half),
      .ev_done(ev_done), .irq_en(irq_en), .irq(irq5));

   int n_chk = 0, n_fail = 0;
   logic [31:0] exp7 = '0, exp5 = '0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   // reference clear mask: data masked by byte enables, only at offset 4
   function automatic logic [31:0] ref_mask(input logic s, input logic w,
      input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
      logic [31:0] m = '0;
      if (s && w && a == 4'd4)
         for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = d[8*b +: 8];
      return m;
   endfunction

   function automatic logic [31:0] ref_next(input logic [31:0] cur,
      input logic [6:0] te, input logic [6:0] ht, input logic [6:0] tc,
      input logic [31:0] clr, input int n);
      logic [31:0] r = '0;
      for (int ch = 0; ch < n; ch++) begin
         logic [3:0] c = cur[4*ch +: 4];
         logic [3:0] k = clr[4*ch +: 4];
         r[4*ch+3] = te[ch] | (c[3] & ~(k[3] | k[0]));
         r[4*ch+2] = ht[ch] | (c[2] & ~(k[2] | k[0]));
         r[4*ch+1] = tc[ch] | (c[1] & ~(k[1] | k[0]));
         r[4*ch+0] = te[ch] | ht[ch] | tc[ch] | (c[0] & ~k[0]);
      end
      return r;
   endfunction

   function automatic logic [6:0] ref_irq(input logic [31:0] st, input logic [6:0] en);
      logic [6:0] q;
      for (int ch = 0; ch < 7; ch++) q[ch] = en[ch] & (|st[4*ch +: 4]);
      return q;
   endfunction

   // drive one cycle of stimulus, then read the status word and compare
   task automatic step(input string tag, input logic [6:0] te, input logic [6:0] ht,
      input logic [6:0] tc, input logic w, input logic [3:0] a,
      input logic [3:0] be, input logic [31:0] d);
      logic [31:0] m;
      ev_err = te; ev_half = ht; ev_done = tc;
      bus_sel = w; bus_wr = w; bus_addr = a; bus_be = be; bus_wdata = d;
      m = ref_mask(w, w, a, be, d);
      exp7 = ref_next(exp7, te, ht, tc, m, 7);
      exp5 = ref_next(exp5, te, ht, tc, m, 5);
      @(posedge clk); #1;
      ev_err = '0; ev_half = '0; ev_done = '0;
      bus_sel = 1; bus_wr = 0; bus_addr = 4'd0; bus_be = '0; bus_wdata = '0;
      #1;
      chk(tag, rd7, exp7);
      chk({tag, " R9 five-channel"}, rd5, exp5);
      chk({tag, " R10 irq"}, {25'd0, irq7}, {25'd0, ref_irq(exp7, irq_en)});
      chk({tag, " R9 R10 irq five-channel"}, {25'd0, irq5}, {25'd0, ref_irq(exp5, irq_en)});
   endtask

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed = 32'h1F2E;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      bus_sel = 1; #1;
      chk("R1 reset status", rd7, 32'h0);
      chk("R1 reset irq", {25'd0, irq7}, 32'h0);

      irq_en = 7'h7F;
      // R2 R3: error on channel 3 -> bits 11 and 8
      step("R2 R3 ch3 error layout", 7'b0000100, 0, 0, 0, 0, 0, 0);
      chk("R2 explicit value", rd7, 32'h0000_0900);
      // R3: complete on ch1, half on ch7
      step("R3 events", 7'b0, 7'b1000000, 7'b0000001, 0, 0, 0, 0);
      chk("R2 R3 explicit", rd7, 32'h0500_0903);
      // R8: write to status offset changes nothing; clear word reads zero
      step("R8 write status ignored", 0, 0, 0, 1, 4'd0, 4'hF, 32'hFFFF_FFFF);
      chk("R8 explicit", rd7, 32'h0500_0903);
      bus_addr = 4'd4; #1;
      chk("R8 clear word reads zero", rd7, 32'h0);
      chk("R8 reserved bits", {28'd0, rd7[31:28]}, 32'h0);
      // R4: clear only complete flag of ch1; zeros ignored
      step("R4 clear one bit", 0, 0, 0, 1, 4'd4, 4'hF, 32'h0000_0002);
      chk("R4 explicit", rd7, 32'h0500_0901);
      // R5: summary clear of ch3 empties its nibble
      step("R5 summary clear", 0, 0, 0, 1, 4'd4, 4'hF, 32'h0000_0100);
      chk("R5 explicit", rd7, 32'h0500_0001);
      // R6: all-ones with only lane 3 enabled clears ch7 only
      step("R6 lane mask", 0, 0, 0, 1, 4'd4, 4'b1000, 32'hFFFF_FFFF);
      chk("R6 explicit", rd7, 32'h0000_0001);
      // R7: set and clear collide on ch2 error
      step("R7 set wins", 7'b0000010, 0, 0, 1, 4'd4, 4'hF, 32'h0000_0080);
      chk("R7 explicit", {24'd0, rd7[7:4]}, 32'h9);
      // R9: events on channels 6 and 7 in the five-channel instance
      step("R9 upper channels", 7'b1100000, 7'b1100000, 7'b1100000, 0, 0, 0, 0);
      chk("R9 explicit upper zero", {8'd0, rd5[31:20], 12'd0}, 32'h0);
      // R10: enables off drop the requests
      irq_en = 7'h00;
      step("R10 enables off", 0, 0, 0, 0, 0, 0, 0);
      chk("R10 explicit", {25'd0, irq7}, 32'h0);

      for (int i = 0; i < 3000; i++) begin
         logic [6:0] te, ht, tc;
         logic w;
         te = (($urandom % 4) == 0) ? 7'($urandom) & 7'($urandom) : 7'h0;
         ht = (($urandom % 4) == 0) ? 7'($urandom) & 7'($urandom) : 7'h0;
         tc = (($urandom % 4) == 0) ? 7'($urandom) & 7'($urandom) : 7'h0;
         w  = ($urandom % 2) == 0;
         irq_en = 7'($urandom);
         step("R3 R4 R5 R6 R7 R10 random", te, ht, tc, w,
              (($urandom % 5) == 0) ? 4'd0 : 4'd4, 4'($urandom), $urandom);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule